// File: doc/BRIEF.md
# Mailbox Command Message Sequencer

This block runs one command exchange with a coprocessor on behalf of a host-side requester. The requester gives a sixteen-word command message and raises a request. The block takes a private copy of the message, the protocol version and the poll divider when it acknowledges the request. It then runs the whole exchange as a master on a simple register bus that points into the coprocessor's register space. That bus space holds two mailbox registers and a shared message RAM.

The exchange runs in this order. The block waits until the coprocessor's outgoing mailbox is empty. It copies the message into the shared RAM and rings the doorbell. It then polls for a nonzero reply code and reads the sixteen reply words back. It checks the reply checksum, whose position follows from the argument count, and releases the exchange by writing zero to a mailbox chosen by the protocol version. Both waits are bounded by a poll count, and a programmable divider sets the time between polls. The result is a 32-bit status code, a small status index and the reply words, all announced by a single-cycle done pulse. The block does not interpret the reply payload.

The bus handshake is simple. An access is offered with `busValid` and completes on the clock edge at which `busReady` is high. Read data is taken from `busRdata` in that same cycle.

Top module: `mbox_cmd_seq`

## Requirements
- R1: Bus addresses are fixed. The mailbox toward the coprocessor is at 0x010. The mailbox toward the host is at 0x014. Message word i is at 0x100 + 4*i. While `busValid` is high and `busReady` is low, the address, direction and write data hold steady.
- R2: In the cycle after `reqAck`, the block issues a read of 0x014. While that mailbox reads nonzero, the block polls it again. With `busReady` high throughout, two consecutive polls complete `pollDiv`+2 cycles apart.
- R3: The block reads 0x014 at most POLL_LIMIT (default 1000) times. If every one of these reads returns nonzero, the command ends with status code 0x80000010 and index 5, and the block makes no bus write at all.
- R4: Once the mailbox reads zero, the block writes the sixteen captured template words to message words 0 through 15 in ascending order. It then writes 1 to 0x010.
- R5: After the doorbell, the block polls 0x014 for a nonzero reply code, with the same poll spacing and the same limit of POLL_LIMIT reads. If the limit is exhausted, the status is 0x80000010 with index 5, and the exchange is still released.
- R6: When the reply code arrives, the block reads all sixteen message words. Word i is then shown on `rspWords[32*i +: 32]` from the done pulse until the next acknowledge.
- R7: Reply word 2 holds the argument count N. When N is at most 12, word N+3 must equal the modulo-2^32 sum of words 0 through N+2. A count above 12 or a sum mismatch replaces any reply code with 0x80000004 (index 3).
- R8: Reply code 0x00000001 gives index 0. Any other code is reported unchanged. Its index is 1 plus the position of the lowest set bit among bits 4..0, or 7 when none of those bits is set.
- R9: After a reply or a reply timeout, the block writes 0 exactly once to release the exchange. The target is 0x014 when the captured protocol version is below 3, and 0x010 otherwise.
- R10: Only one command is in flight. `reqAck` rises only while the block is idle, never between an acknowledge and its done pulse. `done` lasts one cycle. The block issues no bus access outside a command.
- R11: `statusCode` and `statusIdx` are 0 after reset. They change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Command request, held until acknowledged |
| reqAck | output | 1 | Request accepted; inputs are captured in this cycle |
| reqTemplate | input | NUM_WORDS*DATA_W | Command message, word i at bits 32*i |
| protoVer | input | VER_W | Protocol version; selects the release mailbox |
| pollDiv | input | PRESC_W | Poll divider; polls are pollDiv+2 cycles apart |
| busValid | output | 1 | Bus access request |
| busWrite | output | 1 | 1 for write, 0 for read |
| busAddr | output | ADDR_W | Byte address in coprocessor register space |
| busWdata | output | DATA_W | Write data |
| busReady | input | 1 | Access completes on this edge |
| busRdata | input | DATA_W | Read data, valid when busReady is high |
| done | output | 1 | One-cycle end-of-command pulse |
| statusCode | output | DATA_W | Final status code |
| statusIdx | output | 3 | Compact status index |
| rspWords | output | NUM_WORDS*DATA_W | Reply words read back |

## Verification
A wrong poll counter shows at the ports in one of two ways. The number of mailbox reads before a timeout status is wrong, or a timeout fires early, and both show by the done pulse of that same command. A wrong word index shows as misplaced template writes on the bus within sixteen accesses, or as shifted reply words once done pulses. A wrong checksum window or a wrong latched version shows only in the final status or in the address of the single release write. Every command is therefore scored on its own at its done pulse, with both the bus traffic and the results compared against values computed outside the design.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RDY_RD, S_RDY_WAIT, S_MSG_WR, S_BELL,
    S_RSP_RD, S_RSP_WAIT, S_RB_RD, S_REL
  } seqState_t;

  // Strobes from the control FSM into the datapath
  typedef struct packed {
    logic loadReq;     // capture template, version and divider
    logic clrIdx;
    logic incIdx;
    logic clrPoll;
    logic incPoll;
    logic loadPresc;
    logic decPresc;
    logic capWord;     // store read data into reply word [idx]
    logic capCode;     // store reply code
    logic capTimeout;  // mark the exchange as timed out
    logic finish;      // publish status, pulse done
  } seqStrobe_t;

  localparam int OFS_TO_COP  = 'h010;
  localparam int OFS_TO_HOST = 'h014;
  localparam int OFS_MSG     = 'h100;

  localparam logic [31:0] CODE_OK      = 32'h0000_0001;
  localparam logic [31:0] CODE_CHKSUM  = 32'h8000_0004;
  localparam logic [31:0] CODE_TIMEOUT = 32'h8000_0010;

endpackage

// File: rtl/mbox_seq_dp.sv
module mbox_seq_dp
  import mbox_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_WORDS  = 16,
  parameter int POLL_LIMIT = 1000,
  parameter int PRESC_W    = 16,
  parameter int VER_W      = 4,
  parameter int REL_VER    = 3,
  localparam int IDX_W     = $clog2(NUM_WORDS),
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  seqStrobe_t                    stb,
  input  logic [NUM_WORDS*DATA_W-1:0]   reqTemplate,
  input  logic [VER_W-1:0]              protoVer,
  input  logic [PRESC_W-1:0]            pollDiv,
  input  logic [DATA_W-1:0]             busRdata,
  output logic [IDX_W-1:0]              idx,
  output logic [DATA_W-1:0]             tplWord,
  output logic                          idxLast,
  output logic                          pollLast,
  output logic                          prescZero,
  output logic                          relToHost,
  output logic [NUM_WORDS*DATA_W-1:0]   rspWords,
  output logic [DATA_W-1:0]             statusCode,
  output logic [2:0]                    statusIdx
);

  logic [NUM_WORDS-1:0][DATA_W-1:0] tplReg;
  logic [NUM_WORDS-1:0][DATA_W-1:0] rspReg;
  logic [DATA_W-1:0]  codeReg;
  logic               timedOut;
  logic [POLL_W-1:0]  pollCnt;
  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] divReg;

  assign tplWord   = tplReg[idx];
  assign idxLast   = (idx == IDX_W'(NUM_WORDS - 1));
  assign pollLast  = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign prescZero = (presc == '0);
  assign rspWords  = rspReg;

  // Checksum over the reply window selected by the argument count
  logic [DATA_W-1:0] argCnt, sum;
  logic [IDX_W-1:0]  chkPos;
  logic              chkBad;
  always_comb begin
    argCnt = rspReg[2];
    sum    = '0;
    chkPos = '0;
    chkBad = 1'b1;
    if (argCnt <= DATA_W'(NUM_WORDS - 4)) begin
      chkPos = IDX_W'(argCnt) + IDX_W'(3);
      for (int i = 0; i < NUM_WORDS; i++)
        if (i < int'(argCnt) + 3) sum = sum + rspReg[i];
      chkBad = (sum != rspReg[chkPos]);
    end
  end

  logic [DATA_W-1:0] finalCode;
  always_comb begin
    if (timedOut || stb.capTimeout) finalCode = DATA_W'(CODE_TIMEOUT);
    else if (chkBad)                finalCode = DATA_W'(CODE_CHKSUM);
    else                            finalCode = codeReg;
  end

  function automatic logic [2:0] idxOf(input logic [DATA_W-1:0] c);
    logic [2:0] r;
    r = 3'd7;
    if (c == DATA_W'(CODE_OK)) r = 3'd0;
    else
      for (int b = 4; b >= 0; b--)
        if (c[b]) r = 3'(b + 1);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tplReg     <= '0;
      rspReg     <= '0;
      codeReg    <= '0;
      timedOut   <= 1'b0;
      pollCnt    <= '0;
      presc      <= '0;
      divReg     <= '0;
      idx        <= '0;
      relToHost  <= 1'b0;
      statusCode <= '0;
      statusIdx  <= '0;
    end else begin
      if (stb.loadReq) begin
        tplReg    <= reqTemplate;
        divReg    <= pollDiv;
        relToHost <= (protoVer < VER_W'(REL_VER));
        timedOut  <= 1'b0;
      end
      if (stb.clrPoll)        pollCnt <= '0;
      else if (stb.incPoll)   pollCnt <= pollCnt + 1'b1;
      if (stb.loadPresc)      presc <= divReg;
      else if (stb.decPresc)  presc <= presc - 1'b1;
      if (stb.clrIdx)         idx <= '0;
      else if (stb.incIdx)    idx <= idx + 1'b1;
      if (stb.capWord)        rspReg[idx] <= busRdata;
      if (stb.capCode)        codeReg <= busRdata;
      if (stb.capTimeout)     timedOut <= 1'b1;
      if (stb.finish) begin
        statusCode <= finalCode;
        statusIdx  <= idxOf(finalCode);
      end
    end
  end

endmodule

// File: rtl/mbox_seq_ctl.sv
module mbox_seq_ctl
  import mbox_seq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 16,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  output logic               reqAck,
  output logic               busValid,
  output logic               busWrite,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busWdata,
  input  logic               busReady,
  input  logic [DATA_W-1:0]  busRdata,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  tplWord,
  input  logic               idxLast,
  input  logic               pollLast,
  input  logic               prescZero,
  input  logic               relToHost,
  output seqStrobe_t         stb,
  output logic               done
);

  seqState_t st, nxt;

  logic [ADDR_W-1:0] msgAddr;
  assign msgAddr = ADDR_W'(OFS_MSG) + ADDR_W'({idx, 2'b00});

  always_comb begin
    nxt      = st;
    stb      = '0;
    reqAck   = 1'b0;
    busValid = 1'b0;
    busWrite = 1'b0;
    busAddr  = '0;
    busWdata = '0;
    unique case (st)
      S_IDLE: if (reqValid) begin
        reqAck      = 1'b1;
        stb.loadReq = 1'b1;
        stb.clrPoll = 1'b1;
        nxt         = S_RDY_RD;
      end
      S_RDY_RD: begin
        busValid = 1'b1;
        busAddr  = ADDR_W'(OFS_TO_HOST);
        if (busReady) begin
          if (busRdata == '0) begin
            stb.clrIdx = 1'b1;
            nxt        = S_MSG_WR;
          end else if (pollLast) begin
            stb.capTimeout = 1'b1;
            stb.finish     = 1'b1;
            nxt            = S_IDLE;
          end else begin
            stb.incPoll   = 1'b1;
            stb.loadPresc = 1'b1;
            nxt           = S_RDY_WAIT;
          end
        end
      end
      S_RDY_WAIT, S_RSP_WAIT: begin
        if (prescZero) nxt = (st == S_RDY_WAIT) ? S_RDY_RD : S_RSP_RD;
        else           stb.decPresc = 1'b1;
      end
      S_MSG_WR: begin
        busValid = 1'b1;
        busWrite = 1'b1;
        busAddr  = msgAddr;
        busWdata = tplWord;
        if (busReady) begin
          if (idxLast) nxt = S_BELL;
          else         stb.incIdx = 1'b1;
        end
      end
      S_BELL: begin
        busValid = 1'b1;
        busWrite = 1'b1;
        busAddr  = ADDR_W'(OFS_TO_COP);
        busWdata = DATA_W'(1);
        if (busReady) begin
          stb.clrPoll = 1'b1;
          nxt         = S_RSP_RD;
        end
      end
      S_RSP_RD: begin
        busValid = 1'b1;
        busAddr  = ADDR_W'(OFS_TO_HOST);
        if (busReady) begin
          if (busRdata != '0) begin
            stb.capCode = 1'b1;
            stb.clrIdx  = 1'b1;
            nxt         = S_RB_RD;
          end else if (pollLast) begin
            stb.capTimeout = 1'b1;
            nxt            = S_REL;
          end else begin
            stb.incPoll   = 1'b1;
            stb.loadPresc = 1'b1;
            nxt           = S_RSP_WAIT;
          end
        end
      end
      S_RB_RD: begin
        busValid = 1'b1;
        busAddr  = msgAddr;
        if (busReady) begin
          stb.capWord = 1'b1;
          if (idxLast) nxt = S_REL;
          else         stb.incIdx = 1'b1;
        end
      end
      S_REL: begin
        busValid = 1'b1;
        busWrite = 1'b1;
        busAddr  = relToHost ? ADDR_W'(OFS_TO_HOST) : ADDR_W'(OFS_TO_COP);
        if (busReady) begin
          stb.finish = 1'b1;
          nxt        = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
    end else begin
      st   <= nxt;
      done <= stb.finish;
    end
  end

endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int NUM_WORDS  = 16,
  parameter int POLL_LIMIT = 1000,
  parameter int PRESC_W    = 16,
  parameter int VER_W      = 4,
  parameter int REL_VER    = 3,
  localparam int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reqValid,
  output logic                         reqAck,
  input  logic [NUM_WORDS*DATA_W-1:0]  reqTemplate,
  input  logic [VER_W-1:0]             protoVer,
  input  logic [PRESC_W-1:0]           pollDiv,
  output logic                         busValid,
  output logic                         busWrite,
  output logic [ADDR_W-1:0]            busAddr,
  output logic [DATA_W-1:0]            busWdata,
  input  logic                         busReady,
  input  logic [DATA_W-1:0]            busRdata,
  output logic                         done,
  output logic [DATA_W-1:0]            statusCode,
  output logic [2:0]                   statusIdx,
  output logic [NUM_WORDS*DATA_W-1:0]  rspWords
);

  seqStrobe_t        stb;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] tplWord;
  logic              idxLast, pollLast, prescZero, relToHost;

  mbox_seq_ctl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAck(reqAck),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata),
    .idx(idx), .tplWord(tplWord), .idxLast(idxLast), .pollLast(pollLast),
    .prescZero(prescZero), .relToHost(relToHost), .stb(stb), .done(done)
  );

  mbox_seq_dp #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .POLL_LIMIT(POLL_LIMIT),
    .PRESC_W(PRESC_W), .VER_W(VER_W), .REL_VER(REL_VER)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reqTemplate(reqTemplate),
    .protoVer(protoVer), .pollDiv(pollDiv), .busRdata(busRdata),
    .idx(idx), .tplWord(tplWord), .idxLast(idxLast), .pollLast(pollLast),
    .prescZero(prescZero), .relToHost(relToHost), .rspWords(rspWords),
    .statusCode(statusCode), .statusIdx(statusIdx)
  );

endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk
  import mbox_seq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int VER_W   = 4,
  parameter int REL_VER = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqAck,
  input logic [VER_W-1:0]  protoVer,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busReady,
  input logic              done,
  input logic [DATA_W-1:0] statusCode,
  input logic [2:0]        statusIdx
);

  logic inFlight, relHost;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inFlight <= 1'b0;
      relHost  <= 1'b0;
    end else begin
      if (reqAck) begin
        inFlight <= 1'b1;
        relHost  <= (protoVer < VER_W'(REL_VER));
      end else if (done) inFlight <= 1'b0;
    end
  end

  p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reqAck |-> (!inFlight || done));

  p_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busValid |-> inFlight);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_first_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqAck |=> (busValid && !busWrite && busAddr == ADDR_W'(OFS_TO_HOST)));

  p_bus_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && !busReady) |=>
      (busValid && $stable(busAddr) && $stable(busWrite) && $stable(busWdata)));

  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(statusCode) && $stable(statusIdx)));

  p_release_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && busWrite && busWdata == '0 &&
     (busAddr == ADDR_W'(OFS_TO_HOST) || busAddr == ADDR_W'(OFS_TO_COP)))
      |-> (busAddr == (relHost ? ADDR_W'(OFS_TO_HOST) : ADDR_W'(OFS_TO_COP))));

  p_ok_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && statusCode == DATA_W'(CODE_OK)) |-> (statusIdx == 3'd0));

endmodule

bind mbox_cmd_seq mbox_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VER_W(VER_W), .REL_VER(REL_VER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reqAck(reqAck), .protoVer(protoVer),
  .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busReady(busReady), .done(done),
  .statusCode(statusCode), .statusIdx(statusIdx)
);

// File: tb/sim_mbox_cmd_seq.sv
module sim_mbox_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int PL = 1000;
  localparam int PW = 16;
  localparam int VW = 4;
  localparam int IMG_W = NW * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqAck;
  logic [IMG_W-1:0] reqTemplate = '0;
  logic [VW-1:0] protoVer = '0;
  logic [PW-1:0] pollDiv = '0;
  logic busValid, busWrite, busReady;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata, busRdata;
  logic done;
  logic [DW-1:0] statusCode;
  logic [2:0] statusIdx;
  logic [IMG_W-1:0] rspWords;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAck(reqAck),
    .reqTemplate(reqTemplate), .protoVer(protoVer), .pollDiv(pollDiv),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata),
    .done(done), .statusCode(statusCode), .statusIdx(statusIdx),
    .rspWords(rspWords)
  );

  typedef struct {
    int preBusy; int rspLat; logic [31:0] code;
    logic [IMG_W-1:0] image; logic [IMG_W-1:0] tpl; int div; bit stall;
  } cfg_t;
  typedef struct {
    string tag; logic [31:0] code; logic [2:0] idx; bit chkRsp;
    logic [IMG_W-1:0] image; int relAddr; bit chkTpl; int pollReads; bit chkSpacing;
  } exp_t;

  cfg_t cfgQ[$];
  exp_t expQ[$];

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(bit ok, string tag, string what, logic [IMG_W-1:0] act, logic [IMG_W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // ---------------- coprocessor model ----------------
  int preLeft = 0, latLeft = 0, curDiv = 0, writes = 0, relCount = 0;
  int relAddrSeen = 0, hostReads = 0, lastPollCyc = -1, wrIdx = 0, cyc = 0;
  bit rang = 0, spacingBad = 0, orderBad = 0, tplOk = 0, curStall = 0;
  logic [31:0] curCode = '0;
  logic [IMG_W-1:0] ram = '0, curImage = '0, curTpl = '0;

  assign busReady = curStall ? ((cyc % 3) != 0) : 1'b1;

  always_comb begin
    busRdata = '0;
    if (busAddr == 12'h014)
      busRdata = !rang ? ((preLeft > 0) ? 32'hBAD0_0001 : 32'h0)
                       : ((latLeft > 0) ? 32'h0 : curCode);
    else if (busAddr >= 12'h100 && busAddr < 12'h140)
      busRdata = ram[32*((int'(busAddr) - 256) / 4) +: 32];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reqAck) begin : popCfg
      cfg_t c;
      c = cfgQ.pop_front();
      preLeft <= c.preBusy; latLeft <= c.rspLat; curCode <= c.code;
      curImage <= c.image; curTpl <= c.tpl; curDiv <= c.div; curStall <= c.stall;
      rang <= 0; writes <= 0; relCount <= 0; relAddrSeen <= 0; hostReads <= 0;
      lastPollCyc <= -1; spacingBad <= 0; orderBad <= 0; tplOk <= 0; wrIdx <= 0;
    end else if (busValid && busReady) begin
      if (busWrite) begin
        writes <= writes + 1;
        if (busAddr >= 12'h100 && busAddr < 12'h140) begin
          if (int'(busAddr) != 'h100 + 4*wrIdx || rang) orderBad <= 1;
          ram[32*((int'(busAddr) - 256) / 4) +: 32] <= busWdata;
          wrIdx <= wrIdx + 1;
        end else if (busAddr == 12'h010 && busWdata == 32'd1) begin
          rang  <= 1;
          tplOk <= (ram == curTpl) && (wrIdx == NW);
          ram   <= curImage;
        end else if (busWdata == 32'd0 && (busAddr == 12'h010 || busAddr == 12'h014)) begin
          relCount    <= relCount + 1;
          relAddrSeen <= int'(busAddr);
        end else orderBad <= 1;
      end else if (busAddr == 12'h014) begin
        hostReads <= hostReads + 1;
        if (!rang) begin
          if (lastPollCyc >= 0 && cyc - lastPollCyc != curDiv + 2) spacingBad <= 1;
          lastPollCyc <= cyc;
          if (preLeft > 0) preLeft <= preLeft - 1;
        end else if (latLeft > 0) latLeft <= latLeft - 1;
      end
    end
  end

  // ---------------- scoreboard monitor ----------------
  bit busyTb = 0, holdBad = 0;
  logic [31:0] heldCode = '0;
  logic [2:0] heldIdx = '0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin : score
        exp_t e;
        if (expQ.size() == 0) check(0, "R10", "unexpected done", 1, 0);
        else begin
          e = expQ.pop_front();
          check(statusCode == e.code, e.tag, "statusCode", statusCode, e.code);
          check(statusIdx == e.idx, e.tag, "statusIdx", statusIdx, e.idx);
          check(!holdBad, "R11", "status moved without done", holdBad, 0);
          if (e.chkRsp) check(rspWords == e.image, "R6", "reply words", rspWords, e.image);
          if (e.relAddr != 0) begin
            check(relCount == 1, "R9", "release count", relCount, 1);
            check(relAddrSeen == e.relAddr, "R9", "release target", relAddrSeen, e.relAddr);
          end else begin
            check(writes == 0, "R3", "writes after ready timeout", writes, 0);
          end
          if (e.chkTpl) check(tplOk && !orderBad, "R1/R4", "template writes and doorbell", {tplOk, orderBad}, 2'b10);
          if (e.pollReads != 0) check(hostReads == e.pollReads, e.tag, "mailbox reads", hostReads, e.pollReads);
          if (e.chkSpacing) check(!spacingBad, "R2", "poll spacing", spacingBad, 0);
        end
        busyTb   = 0;
        heldCode = statusCode;
        heldIdx  = statusIdx;
        holdBad  = 0;
      end else if (statusCode != heldCode || statusIdx != heldIdx) holdBad = 1;
      if (reqAck) begin
        check(!busyTb, "R10", "ack while a command is in flight", busyTb, 0);
        busyTb = 1;
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [IMG_W-1:0] mkImage(int n, logic [31:0] seed, bit corrupt);
    logic [NW-1:0][31:0] w;
    logic [31:0] s;
    w[0] = 32'd2; w[1] = seed; w[2] = n;
    for (int i = 3; i < NW; i++) w[i] = (seed ^ (32'h0101_0101 * i)) + i;
    if (n <= NW - 4) begin
      s = '0;
      for (int i = 0; i < n + 3; i++) s = s + w[i];
      w[n + 3] = corrupt ? s + 32'd1 : s;
    end
    return w;
  endfunction

  function automatic logic [IMG_W-1:0] mkTpl(logic [31:0] seed);
    logic [NW-1:0][31:0] w;
    for (int i = 0; i < NW; i++) w[i] = seed * (i + 3) ^ {i[7:0], 24'h5A5A5A};
    w[0] = 32'd1;
    return w;
  endfunction

  // kind: 0 reply, 1 ready timeout, 2 reply timeout
  task automatic runCase(string tag, int kind, int ver, int div, int preBusy, int lat,
                         logic [31:0] rcode, int n, bit corrupt, bit stall,
                         logic [31:0] eCode, logic [2:0] eIdx);
    cfg_t c; exp_t e;
    logic [31:0] seed;
    seed = 32'h1234_0000 + n * 32'h111 + rcode[7:0] + ver;
    c.preBusy = (kind == 1) ? (1 << 30) : preBusy;
    c.rspLat  = (kind == 2) ? (1 << 30) : lat;
    c.code = rcode; c.image = mkImage(n, seed, corrupt); c.tpl = mkTpl(seed ^ 32'hC0DE);
    c.div = div; c.stall = stall;
    e.tag = tag; e.code = eCode; e.idx = eIdx; e.chkRsp = (kind == 0); e.image = c.image;
    e.relAddr = (kind == 1) ? 0 : ((ver < 3) ? 'h14 : 'h10);
    e.chkTpl = (kind != 1);
    e.pollReads = (kind == 1) ? PL : ((kind == 2) ? preBusy + 1 + PL : 0);
    e.chkSpacing = !stall;
    cfgQ.push_back(c);
    expQ.push_back(e);
    @(negedge clk);
    reqTemplate = c.tpl; protoVer = VW'(ver); pollDiv = PW'(div); reqValid = 1'b1;
    #1;
    while (!reqAck) begin @(negedge clk); #1; end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(statusCode == 0 && statusIdx == 0, "R11", "reset status", {statusCode, statusIdx}, 0);
    check(!done && !reqAck && !busValid, "R10", "reset idle outputs", {done, reqAck, busValid}, 0);

    runCase("R6", 0, 2, 1, 0, 0, 32'h1, 1, 0, 0, 32'h1, 3'd0);
    runCase("R2", 0, 3, 2, 3, 2, 32'h1, 0, 0, 0, 32'h1, 3'd0);
    runCase("R8", 0, 2, 0, 0, 1, 32'h8000_0002, 2, 0, 0, 32'h8000_0002, 3'd2);
    runCase("R7", 0, 2, 0, 0, 0, 32'h1, 3, 1, 0, 32'h8000_0004, 3'd3);
    runCase("R7", 0, 4, 1, 1, 1, 32'h1, 13, 0, 0, 32'h8000_0004, 3'd3);
    runCase("R7", 0, 1, 1, 2, 0, 32'h1, 12, 0, 1, 32'h1, 3'd0);
    runCase("R8", 0, 2, 2, 0, 3, 32'h8000_0008, 4, 0, 1, 32'h8000_0008, 3'd4);
    runCase("R8", 0, 3, 0, 0, 0, 32'h8000_000C, 5, 0, 0, 32'h8000_000C, 3'd3);
    runCase("R8", 0, 0, 0, 0, 0, 32'h8000_0000, 2, 0, 0, 32'h8000_0000, 3'd7);
    runCase("R3", 1, 2, 0, 0, 0, 32'h1, 1, 0, 0, 32'h8000_0010, 3'd5);
    runCase("R5", 2, 5, 1, 1, 0, 32'h1, 1, 0, 0, 32'h8000_0010, 3'd5);
    runCase("R9", 0, 7, 0, 0, 0, 32'h8000_0001, 6, 1, 0, 32'h8000_0004, 3'd3);

    while (expQ.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(cfgQ.size() == 0, "R10", "every request acknowledged once", cfgQ.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", expQ.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule